// File: doc/BRIEF.md
# Ring Lock Arbiter

This block sits beside one processor core on a one-way message ring and looks after a set of numbered hardware locks for that core. The core asks for a lock by reading a decoded I/O address and gives the lock back by writing the same address. When the core's own state for the lock settles the outcome, the unit answers on the spot. When it does not, the unit puts an acquire message on the ring and waits until the message has been all the way round. Every other unit on the ring may turn that message into a denial on the way. The unit also services messages from other cores as they pass through. It denies acquires for locks it holds, drops locks that a remote release names, and forgets the re-grant shortcut for a lock as soon as another core asks for it.

Each lock is in one of three states: free, held, and last-holder. The last-holder state is entered when the core releases a lock it held. While no other core has asked for that lock, it lets the core take the lock back at once, with no ring traffic. Ring messages are registered through the unit with one cycle of latency. A message that comes back to the core that sent it is taken off the ring.

Top module: `ring_lock_unit`

## Requirements
- R1: After reset every lock is free, `rd_valid` is 0 and `rout_valid` is 0, so the first acquire of any lock must use the ring.
- R2: An access is a lock operation only when `io_addr[2:0]` equals 5. The lock number is `io_addr[8:3]`. Any read or write with another low code gives no read response and no ring message.
- R3: A read (acquire) of a lock this core holds returns `rd_data`=2 with `rd_valid` high one cycle later, and sends nothing on the ring.
- R4: A read of a free lock sends one ring message two cycles later with kind 1 (acquire), `rout_src`=CORE_ID and the lock number. `rd_valid` stays low until that message returns.
- R5: When the core's own acquire comes back with kind 1, the lock becomes held and the read returns 1 one cycle later. When it comes back with kind 2 (denied), the read returns 0 and the lock stays free.
- R6: A message from another core is forwarded one cycle later with the same source and lock. An acquire (kind 1) for a lock this core holds leaves as kind 2. All other messages keep their kind.
- R7: A write (release) of a held lock moves it to last-holder without ring traffic. A later read of that lock returns 2 at once and makes it held again.
- R8: A foreign acquire for a lock in last-holder state is forwarded unchanged and makes the lock free, so the next read of it goes to the ring.
- R9: A write of a lock this core does not hold sends a release message (kind 3). A foreign release for a held lock makes it free.
- R10: A message whose source is this core is never forwarded. A pending outgoing message waits while incoming foreign traffic fills the output slot, and goes out in the first cycle the slot is free.
- R11: While an acquire or a release is waiting for the ring, further reads and writes are ignored.
- R12: When a foreign message and a local operation touch the same lock in one cycle, the message is applied first and the local operation then acts on the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address: low SEL_W bits select, upper LOCK_W bits give the lock number |
| io_rd | input | 1 | One-cycle read strobe (acquire) |
| io_wr | input | 1 | One-cycle write strobe (release) |
| rd_valid | output | 1 | Read result valid pulse |
| rd_data | output | 2 | Read result: 0 denied, 1 won by ring, 2 already held |
| rin_valid | input | 1 | Incoming ring message valid |
| rin_kind | input | 2 | Incoming kind: 1 acquire, 2 denied, 3 release |
| rin_src | input | CORE_W | Incoming source core |
| rin_lock | input | LOCK_W | Incoming lock number |
| rout_valid | output | 1 | Outgoing ring message valid |
| rout_kind | output | 2 | Outgoing kind |
| rout_src | output | CORE_W | Outgoing source core |
| rout_lock | output | LOCK_W | Outgoing lock number |

## Verification
The hardest case to reach from the ports is a foreign message and a local operation that hit the same lock in the same cycle, since only one order of the two gives the right result. The bench first puts a lock into last-holder or held state. It then drives a foreign acquire and the core's read or write on the same clock edge, and checks both the forwarded message kind and whether the local operation went to the ring. A second hard case is an outgoing message held back by a steady stream of foreign traffic. The bench makes this by keeping the ring input busy for several cycles right after the acquire is issued.

// File: rtl/rlu_pkg.sv
package rlu_pkg;
   typedef enum logic [1:0] {
      LK_FREE = 2'd0,
      LK_HELD = 2'd1,
      LK_LAST = 2'd2
   } lk_state_t;

   typedef enum logic [1:0] {
      MT_NONE = 2'd0,
      MT_ACQ  = 2'd1,
      MT_DENY = 2'd2,
      MT_REL  = 2'd3
   } msg_kind_t;

   localparam logic [1:0] RES_FAIL = 2'd0;
   localparam logic [1:0] RES_WON  = 2'd1;
   localparam logic [1:0] RES_HAVE = 2'd2;
endpackage

// File: rtl/rlu_io_decode.sv
module rlu_io_decode #(
   parameter int ADDR_W   = 9,
   parameter int SEL_W    = 3,
   parameter int SEL_CODE = 5,
   parameter int LOCK_W   = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [LOCK_W-1:0] lock
);
   if (ADDR_W != SEL_W + LOCK_W) begin : g_bad_width
      $error("rlu_io_decode: ADDR_W must equal SEL_W + LOCK_W");
   end
   if (SEL_CODE >= (1 << SEL_W)) begin : g_bad_code
      $error("rlu_io_decode: SEL_CODE does not fit in SEL_W bits");
   end

   localparam logic [SEL_W-1:0] SEL_VAL = SEL_CODE[SEL_W-1:0];

   assign hit  = (addr[SEL_W-1:0] == SEL_VAL);
   assign lock = addr[ADDR_W-1:SEL_W];
endmodule

// File: rtl/rlu_lock_table.sv
module rlu_lock_table
   import rlu_pkg::*;
#(
   parameter int LOCK_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ring_we,
   input  logic [LOCK_W-1:0] ring_idx,
   input  lk_state_t         ring_val,
   input  logic              loc_we,
   input  logic [LOCK_W-1:0] loc_idx,
   input  lk_state_t         loc_val,
   input  logic [LOCK_W-1:0] qa_idx,
   output lk_state_t         qa,
   input  logic [LOCK_W-1:0] qb_idx,
   output lk_state_t         qb
);
   localparam int NLOCKS = 1 << LOCK_W;

   if (LOCK_W < 1 || LOCK_W > 10) begin : g_bad_locks
      $error("rlu_lock_table: LOCK_W out of range");
   end

   lk_state_t cell_q [NLOCKS];
   lk_state_t cell_d [NLOCKS];

   // the local write is computed against the post-ring state, so it wins
   for (genvar i = 0; i < NLOCKS; i++) begin : g_cell
      assign cell_d[i] = (loc_we  && loc_idx  == LOCK_W'(i)) ? loc_val  :
                         (ring_we && ring_idx == LOCK_W'(i)) ? ring_val :
                         cell_q[i];
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NLOCKS; i++) begin
         cell_q[i] <= rst_n ? cell_d[i] : LK_FREE;
      end
   end

   assign qa = cell_q[qa_idx];
   assign qb = cell_q[qb_idx];

   // R1
   state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qa != 2'd3) && (qb != 2'd3));
endmodule

// File: rtl/rlu_ring_port.sv
module rlu_ring_port #(
   parameter int CORE_W  = 4,
   parameter int CORE_ID = 3,
   parameter int LOCK_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fwd_v,
   input  logic [1:0]        fwd_kind,
   input  logic [CORE_W-1:0] fwd_src,
   input  logic [LOCK_W-1:0] fwd_lock,
   input  logic              inj_v,
   input  logic [1:0]        inj_kind,
   input  logic [LOCK_W-1:0] inj_lock,
   output logic              inj_take,
   output logic              out_valid,
   output logic [1:0]        out_kind,
   output logic [CORE_W-1:0] out_src,
   output logic [LOCK_W-1:0] out_lock
);
   if (CORE_ID >= (1 << CORE_W)) begin : g_bad_id
      $error("rlu_ring_port: CORE_ID does not fit in CORE_W bits");
   end

   localparam logic [CORE_W-1:0] MY_ID = CORE_ID[CORE_W-1:0];

   // traffic already on the ring keeps its slot; local messages fill gaps
   assign inj_take = inj_v && !fwd_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_kind  <= 2'd0;
         out_src   <= '0;
         out_lock  <= '0;
      end else if (fwd_v) begin
         out_valid <= 1'b1;
         out_kind  <= fwd_kind;
         out_src   <= fwd_src;
         out_lock  <= fwd_lock;
      end else if (inj_v) begin
         out_valid <= 1'b1;
         out_kind  <= inj_kind;
         out_src   <= MY_ID;
         out_lock  <= inj_lock;
      end else begin
         out_valid <= 1'b0;
      end
   end

   // R6
   fwd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_v |=> out_valid && out_src == $past(fwd_src) && out_lock == $past(fwd_lock));

   // R10
   inj_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_v && !fwd_v) |=> out_valid && out_src == MY_ID && out_lock == $past(inj_lock));
endmodule

// File: rtl/ring_lock_unit.sv
module ring_lock_unit
   import rlu_pkg::*;
#(
   parameter int CORE_W   = 4,
   parameter int CORE_ID  = 3,
   parameter int LOCK_W   = 6,
   parameter int SEL_W    = 3,
   parameter int SEL_CODE = 5,
   parameter int ADDR_W   = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   output logic              rd_valid,
   output logic [1:0]        rd_data,
   input  logic              rin_valid,
   input  logic [1:0]        rin_kind,
   input  logic [CORE_W-1:0] rin_src,
   input  logic [LOCK_W-1:0] rin_lock,
   output logic              rout_valid,
   output logic [1:0]        rout_kind,
   output logic [CORE_W-1:0] rout_src,
   output logic [LOCK_W-1:0] rout_lock
);
   localparam logic [CORE_W-1:0] MY_ID = CORE_ID[CORE_W-1:0];

   logic              op_hit;
   logic [LOCK_W-1:0] op_lock;
   lk_state_t         ring_st, op_st, mid_st;
   logic              ring_we, loc_we;
   lk_state_t         ring_val, loc_val;
   logic [1:0]        fwd_kind;
   logic              in_mine, in_other, ret_hit;
   logic              busy, go_rd, go_wr, rd_now, new_inj, inj_take;
   logic [1:0]        new_kind;

   logic              wait_q, inj_v_q, rd_valid_q;
   logic [LOCK_W-1:0] wait_lock_q, inj_lock_q;
   logic [1:0]        inj_kind_q, rd_data_q;

   rlu_io_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .SEL_CODE(SEL_CODE), .LOCK_W(LOCK_W))
      i_dec (.addr(io_addr), .hit(op_hit), .lock(op_lock));

   rlu_lock_table #(.LOCK_W(LOCK_W)) i_tab (
      .clk(clk), .rst_n(rst_n),
      .ring_we(ring_we), .ring_idx(rin_lock), .ring_val(ring_val),
      .loc_we(loc_we), .loc_idx(op_lock), .loc_val(loc_val),
      .qa_idx(rin_lock), .qa(ring_st), .qb_idx(op_lock), .qb(op_st));

   assign in_mine  = rin_valid && (rin_src == MY_ID);
   assign in_other = rin_valid && !in_mine;
   assign ret_hit  = in_mine && wait_q && (rin_lock == wait_lock_q) &&
                     (rin_kind == MT_ACQ || rin_kind == MT_DENY);
   assign busy     = wait_q || inj_v_q;

   // ring side: acts on the stored state of the passing lock
   always_comb begin
      ring_we  = 1'b0;
      ring_val = LK_FREE;
      fwd_kind = rin_kind;
      if (in_other) begin
         if (rin_kind == MT_ACQ) begin
            if (ring_st == LK_HELD) fwd_kind = MT_DENY;
            else if (ring_st == LK_LAST) ring_we = 1'b1;
         end else if (rin_kind == MT_REL && ring_st == LK_HELD) begin
            ring_we = 1'b1;
         end
      end
      if (ret_hit && rin_kind == MT_ACQ) begin
         ring_we  = 1'b1;
         ring_val = LK_HELD;
      end
   end

   // local side: sees the state as left by this cycle's ring message
   assign mid_st = (ring_we && rin_lock == op_lock) ? ring_val : op_st;
   assign go_rd  = io_rd && op_hit && !busy;
   assign go_wr  = io_wr && op_hit && !busy && !io_rd;

   always_comb begin
      loc_we   = 1'b0;
      loc_val  = LK_FREE;
      rd_now   = 1'b0;
      new_inj  = 1'b0;
      new_kind = MT_ACQ;
      if (go_rd) begin
         case (mid_st)
            LK_HELD: rd_now = 1'b1;
            LK_LAST: begin
               rd_now  = 1'b1;
               loc_we  = 1'b1;
               loc_val = LK_HELD;
            end
            default: new_inj = 1'b1;
         endcase
      end else if (go_wr) begin
         if (mid_st == LK_HELD) begin
            loc_we  = 1'b1;
            loc_val = LK_LAST;
         end else begin
            new_inj  = 1'b1;
            new_kind = MT_REL;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_q      <= 1'b0;
         wait_lock_q <= '0;
         inj_v_q     <= 1'b0;
         inj_kind_q  <= 2'd0;
         inj_lock_q  <= '0;
         rd_valid_q  <= 1'b0;
         rd_data_q   <= 2'd0;
      end else begin
         rd_valid_q <= rd_now || ret_hit;
         rd_data_q  <= rd_now ? RES_HAVE : (rin_kind == MT_ACQ ? RES_WON : RES_FAIL);
         if (new_inj) begin
            inj_v_q    <= 1'b1;
            inj_kind_q <= new_kind;
            inj_lock_q <= op_lock;
         end else if (inj_take) begin
            inj_v_q <= 1'b0;
         end
         if (new_inj && new_kind == MT_ACQ) begin
            wait_q      <= 1'b1;
            wait_lock_q <= op_lock;
         end else if (ret_hit) begin
            wait_q <= 1'b0;
         end
      end
   end

   rlu_ring_port #(.CORE_W(CORE_W), .CORE_ID(CORE_ID), .LOCK_W(LOCK_W)) i_port (
      .clk(clk), .rst_n(rst_n),
      .fwd_v(in_other), .fwd_kind(fwd_kind), .fwd_src(rin_src), .fwd_lock(rin_lock),
      .inj_v(inj_v_q), .inj_kind(inj_kind_q), .inj_lock(inj_lock_q), .inj_take(inj_take),
      .out_valid(rout_valid), .out_kind(rout_kind), .out_src(rout_src), .out_lock(rout_lock));

   assign rd_valid = rd_valid_q;
   assign rd_data  = rd_data_q;

   // R3
   rd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> rd_data != 2'd3);

   // R4
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q |-> !rd_valid);

   // R5
   own_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_hit |=> rd_valid && rd_data == ($past(rin_kind) == MT_ACQ ? RES_WON : RES_FAIL));

   // R10
   own_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rout_valid && rout_src == MY_ID) |-> rout_kind != MT_DENY);
endmodule

// File: tb/test_ring_lock_unit.sv
module test_ring_lock_unit;
   localparam int ID = 3;
   localparam int OTHER = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] io_addr = '0;
   logic       io_rd = 1'b0, io_wr = 1'b0;
   logic       rd_valid;
   logic [1:0] rd_data;
   logic       rin_valid = 1'b0;
   logic [1:0] rin_kind = '0;
   logic [3:0] rin_src = '0;
   logic [5:0] rin_lock = '0;
   logic       rout_valid;
   logic [1:0] rout_kind;
   logic [3:0] rout_src;
   logic [5:0] rout_lock;

   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   ring_lock_unit i_ring_lock_unit (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .rin_valid(rin_valid), .rin_kind(rin_kind), .rin_src(rin_src), .rin_lock(rin_lock),
      .rout_valid(rout_valid), .rout_kind(rout_kind), .rout_src(rout_src), .rout_lock(rout_lock));

   // kind: 0 acquire (a = reply kind, 0 = answered locally; b = result)
   //       1 release (a = 1 when a release message is expected)
   //       2 foreign message from core 5 (a = kind in, b = kind out)
   typedef struct packed {
      logic [1:0] kind;
      logic [5:0] lock;
      logic [1:0] a;
      logic [1:0] b;
      logic [3:0] req;
   } vec_t;

   localparam vec_t VECS [15] = '{
      '{2'd0, 6'd10, 2'd1, 2'd1, 4'd5},  // R5 win via ring
      '{2'd0, 6'd10, 2'd0, 2'd2, 4'd3},  // R3 already held
      '{2'd2, 6'd10, 2'd1, 2'd2, 4'd6},  // R6 deny for held lock
      '{2'd2, 6'd20, 2'd1, 2'd1, 4'd6},  // R6 pass unheld lock
      '{2'd1, 6'd10, 2'd0, 2'd0, 4'd7},  // R7 local release
      '{2'd0, 6'd10, 2'd0, 2'd2, 4'd7},  // R7 re-grant shortcut
      '{2'd1, 6'd10, 2'd0, 2'd0, 4'd7},  // R7
      '{2'd2, 6'd10, 2'd1, 2'd1, 4'd8},  // R8 foreign acquire on last-holder
      '{2'd0, 6'd10, 2'd2, 2'd0, 4'd8},  // R8 now goes to ring, denied
      '{2'd0, 6'd63, 2'd1, 2'd1, 4'd5},  // R5
      '{2'd2, 6'd63, 2'd3, 2'd3, 4'd9},  // R9 foreign release
      '{2'd0, 6'd63, 2'd1, 2'd1, 4'd9},  // R9 lock was cleared
      '{2'd1, 6'd0,  2'd1, 2'd0, 4'd9},  // R9 remote release sent
      '{2'd2, 6'd5,  2'd2, 2'd2, 4'd6},  // R6 deny passes unchanged
      '{2'd0, 6'd0,  2'd2, 2'd0, 4'd5}   // R5 denied result
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic quiet(input string req);
      chk(!rd_valid, req, rd_valid, 0);
      chk(!rout_valid, req, rout_valid, 0);
   endtask

   task automatic send_rin(input logic [1:0] k, input int src, input logic [5:0] lk);
      rin_valid = 1'b1; rin_kind = k; rin_src = 4'(src); rin_lock = lk;
   endtask

   task automatic p_op(input logic [5:0] lk, input logic [1:0] reply,
                       input logic [1:0] exp, input string req);
      @(negedge clk);
      io_addr = {lk, 3'd5}; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      if (reply == 2'd0) begin
         chk(rd_valid && rd_data == exp, req, rd_data, exp);
         chk(!rout_valid, req, rout_valid, 0);
      end else begin
         chk(!rd_valid, req, rd_valid, 0);
         @(negedge clk);
         chk(rout_valid && rout_kind == 2'd1 && rout_src == 4'(ID) && rout_lock == lk,
             req, {rout_kind, rout_lock}, {2'd1, lk});
         chk(!rd_valid, req, rd_valid, 0);
         send_rin(reply, ID, lk);
         @(negedge clk);
         rin_valid = 1'b0;
         chk(rd_valid && rd_data == exp, req, rd_data, exp);
         chk(!rout_valid, req, rout_valid, 0);
      end
   endtask

   task automatic v_op(input logic [5:0] lk, input bit ring, input string req);
      @(negedge clk);
      io_addr = {lk, 3'd5}; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      quiet(req);
      @(negedge clk);
      if (ring) chk(rout_valid && rout_kind == 2'd3 && rout_src == 4'(ID) && rout_lock == lk,
                    req, {rout_valid, rout_kind}, {1'b1, 2'd3});
      else chk(!rout_valid, req, rout_valid, 0);
   endtask

   task automatic foreign(input logic [1:0] k, input logic [5:0] lk,
                          input logic [1:0] ek, input string req);
      @(negedge clk);
      send_rin(k, OTHER, lk);
      @(negedge clk);
      rin_valid = 1'b0;
      chk(rout_valid && rout_kind == ek && rout_src == 4'(OTHER) && rout_lock == lk,
          req, rout_kind, ek);
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      quiet("R1");                                  // R1 reset outputs
      p_op(6'd7, 2'd2, 2'd0, "R1");                 // R1 free lock uses ring

      // R2: wrong low code ignored
      @(negedge clk);
      io_addr = {6'd9, 3'd4}; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0; io_addr = {6'd9, 3'd6}; io_wr = 1'b1;
      quiet("R2");
      @(negedge clk);
      io_wr = 1'b0;
      quiet("R2");
      @(negedge clk);
      quiet("R2");

      foreach (VECS[i]) begin
         vec_t v = VECS[i];
         string r = $sformatf("R%0d", v.req);
         case (v.kind)
            2'd0: p_op(v.lock, v.a, v.b, r);
            2'd1: v_op(v.lock, v.a[0], r);
            default: foreign(v.a, v.lock, v.b, r);
         endcase
      end

      // R10: own message removed
      @(negedge clk);
      send_rin(2'd3, ID, 6'd3);
      @(negedge clk);
      rin_valid = 1'b0;
      chk(!rout_valid, "R10", rout_valid, 0);

      // R10: injection waits behind foreign traffic
      @(negedge clk);
      io_addr = {6'd30, 3'd5}; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      send_rin(2'd1, OTHER, 6'd33);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(rout_valid && rout_src == 4'(OTHER), "R10", rout_src, OTHER);
      end
      rin_valid = 1'b0;
      @(negedge clk);
      chk(rout_valid && rout_src == 4'(ID) && rout_lock == 6'd30 && rout_kind == 2'd1,
          "R10", rout_lock, 30);
      send_rin(2'd2, ID, 6'd30);
      @(negedge clk);
      rin_valid = 1'b0;
      chk(rd_valid && rd_data == 2'd0, "R10", rd_data, 0);

      // R11: ops ignored while waiting
      @(negedge clk);
      io_addr = {6'd41, 3'd5}; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      @(negedge clk);
      chk(rout_valid && rout_lock == 6'd41, "R11", rout_lock, 41);
      io_addr = {6'd42, 3'd5}; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      quiet("R11");
      io_addr = {6'd10, 3'd5}; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      quiet("R11");
      send_rin(2'd1, ID, 6'd41);
      @(negedge clk);
      rin_valid = 1'b0;
      chk(rd_valid && rd_data == 2'd1, "R11", rd_data, 1);
      @(negedge clk);
      quiet("R11");

      // R12: last-holder lock, foreign acquire and local read together
      p_op(6'd10, 2'd1, 2'd1, "R12");
      v_op(6'd10, 1'b0, "R12");
      @(negedge clk);
      send_rin(2'd1, OTHER, 6'd10);
      io_addr = {6'd10, 3'd5}; io_rd = 1'b1;
      @(negedge clk);
      rin_valid = 1'b0; io_rd = 1'b0;
      chk(rout_valid && rout_kind == 2'd1 && rout_src == 4'(OTHER), "R12", rout_kind, 1);
      chk(!rd_valid, "R12", rd_valid, 0);
      @(negedge clk);
      chk(rout_valid && rout_src == 4'(ID) && rout_kind == 2'd1 && rout_lock == 6'd10,
          "R12", rout_src, ID);
      send_rin(2'd2, ID, 6'd10);
      @(negedge clk);
      rin_valid = 1'b0;
      chk(rd_valid && rd_data == 2'd0, "R12", rd_data, 0);

      // R12: held lock, foreign acquire and local release together
      p_op(6'd12, 2'd1, 2'd1, "R12");
      @(negedge clk);
      send_rin(2'd1, OTHER, 6'd12);
      io_addr = {6'd12, 3'd5}; io_wr = 1'b1;
      @(negedge clk);
      rin_valid = 1'b0; io_wr = 1'b0;
      chk(rout_valid && rout_kind == 2'd2, "R12", rout_kind, 2);
      @(negedge clk);
      chk(!rout_valid, "R12", rout_valid, 0);
      p_op(6'd12, 2'd0, 2'd2, "R12");
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule